// File: doc/BRIEF.md
# Counter Array Timebase

This block is the common time reference shared by the five compare/capture channels of a small microcontroller's counter array. It keeps a free-running 16-bit up-counter. The counter steps on one of four software-selected events: a slow internal tick, a fast internal tick, an overflow pulse from a neighbouring timer, or a rising edge on an external pin. The pin is brought into the clock domain through a synchronizer first. Counting is allowed only while a run bit is set. It can also be frozen while the processor idles.

When the counter wraps past its top value, a sticky overflow flag is set. That flag, together with an interrupt-enable bit, raises an interrupt request. The block also keeps one event flag per channel. A one-cycle strobe from the channel sets its flag, and software clears it. A two-register special-function-register port exposes the mode settings and the control/status flags. The watchdog enable bit is only stored and driven out; it has no function inside this block.

Top module: `pca_timebase`

## Requirements
- R1: With source select 0, the counter advances once every 6 clocks, or every 12 clocks when `half_speed` is 1.
- R2: With source select 1, the counter advances once every 2 clocks, or every 4 clocks when `half_speed` is 1.
- R3: With source select 2, the counter advances once for each clock in which `tmr_ovf` is 1.
- R4: With source select 3, each rising edge of `ext_pin` advances the counter exactly once, two clocks after the synchronizer's first stage samples the new level. A held level never counts again.
- R5: While the run bit (control register bit 6) is 0, the counter holds its value whatever the selected source does.
- R6: While mode bit 7 is 1 and `cpu_idle` is 1, the counter holds. When mode bit 7 is 0, `cpu_idle` has no effect.
- R7: The overflow flag (control bit 7) is set when the counter steps from all ones to zero. A write of 1 also sets it. It clears only on a write of 0. If a hardware set and a software clear land in the same cycle, the flag ends up set.
- R8: `ovf_irq` is 1 exactly when the overflow flag and the interrupt enable (mode bit 0) are both 1.
- R9: A 1 on `mod_hit[i]` sets channel flag i (control bit i, i = 0..4) at the next edge. Only a control write of 0 clears the flag. A strobe that arrives together with a clearing write leaves the flag set.
- R10: Both registers read 0x00 after reset. The mode register (`sfr_sel`=0) holds idle gating in bit 7, watchdog enable in bit 6 and source select in bits 2:1. The control register (`sfr_sel`=1) holds the flags and the run bit as given above. Bits 5:3 of the mode register and bit 5 of the control register always read 0. `wdog_en` follows mode bit 6.
- R11: A mode write that changes the source select restarts the internal divider. The first internal tick after such a write comes a full period (6/12 or 2/4 clocks) after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_wr | input | 1 | Register write strobe |
| sfr_sel | input | 1 | Register select: 0 mode, 1 control/status |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data of the selected register |
| half_speed | input | 1 | Doubles both internal divide ratios |
| cpu_idle | input | 1 | Processor is in idle |
| tmr_ovf | input | 1 | Overflow pulse from a neighbouring timer |
| ext_pin | input | 1 | Asynchronous external count input |
| mod_hit | input | 5 | Per-channel match/capture strobes |
| count_o | output | 16 | Current counter value |
| ovf_irq | output | 1 | Overflow interrupt request |
| wdog_en | output | 1 | Stored watchdog enable bit |

## Verification
The bench aims at the edges of each count source. A divider that does not restart on a source change would step early after a 0→1→0 select sequence. A pin detector that is level-sensitive would keep counting while `ext_pin` stays high. The bench drives a full 65536-step wrap and places a clearing write on the exact wrap cycle. A design that lets software win that race loses the overflow. A design that lets hardware clear the flag drops the interrupt after the wrap. Channel strobes are also driven together with clearing writes, and the reserved bits are written with ones, to catch flags that lose to software and reserved bits that read back as stored.

// File: rtl/pca_tb_pkg.sv
package pca_tb_pkg;

   typedef enum logic [1:0] {
      SRC_DIV_SLOW = 2'd0,
      SRC_DIV_FAST = 2'd1,
      SRC_TMR_OVF  = 2'd2,
      SRC_EXT_PIN  = 2'd3
   } cnt_src_e;

   // bit positions decoded by software
   localparam int MODE_IDLE_BIT = 7;
   localparam int MODE_WDOG_BIT = 6;
   localparam int MODE_SRC_LSB  = 1;
   localparam int MODE_IE_BIT   = 0;
   localparam int CTRL_OVF_BIT  = 7;
   localparam int CTRL_RUN_BIT  = 6;
   localparam int CTRL_FLAGS_W  = 5;

endpackage

// File: rtl/pca_prescaler.sv
module pca_prescaler #(
   parameter int SLOW_DIV = 6,
   parameter int FAST_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic half_speed,
   input  logic fast_sel,
   output logic tick
);
   localparam int DIV_W = $clog2(2 * SLOW_DIV + 1);
   localparam logic [DIV_W-1:0] SLOW_END   = DIV_W'(SLOW_DIV - 1);
   localparam logic [DIV_W-1:0] SLOW_END_2 = DIV_W'(2 * SLOW_DIV - 1);
   localparam logic [DIV_W-1:0] FAST_END   = DIV_W'(FAST_DIV - 1);
   localparam logic [DIV_W-1:0] FAST_END_2 = DIV_W'(2 * FAST_DIV - 1);

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] end_val;

   always_comb begin
      if (fast_sel) end_val = half_speed ? FAST_END_2 : FAST_END;
      else          end_val = half_speed ? SLOW_END_2 : SLOW_END;
   end

   assign tick = (div_q >= end_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       div_q <= '0;
      else if (restart) div_q <= '0;
      else if (tick)    div_q <= '0;
      else              div_q <= div_q + 1'b1;
   end
endmodule

// File: rtl/pca_pin_edge.sv
module pca_pin_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise
);
   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pca_sfr_regs.sv
module pca_sfr_regs
   import pca_tb_pkg::*;
#(
   parameter int N_MOD = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             sel,
   input  logic [7:0]       wdata,
   input  logic             hw_ovf,
   input  logic [N_MOD-1:0] mod_hit,
   output logic             idle_ctl,
   output logic             wdog_en,
   output cnt_src_e         src_sel,
   output logic             ovf_ie,
   output logic             run,
   output logic             cf,
   output logic [N_MOD-1:0] ccf,
   output logic             src_restart,
   output logic [7:0]       rdata
);
   logic                    wr_mode, wr_ctrl;
   logic [CTRL_FLAGS_W-1:0] flags_rd;
   logic                    unused_wbits;

   assign wr_mode = wr_en & ~sel;
   assign wr_ctrl = wr_en & sel;
   assign src_restart = wr_mode &
                        (wdata[MODE_SRC_LSB +: 2] != src_sel);
   assign unused_wbits = wdata[5];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_ctl <= 1'b0;
         wdog_en  <= 1'b0;
         src_sel  <= SRC_DIV_SLOW;
         ovf_ie   <= 1'b0;
      end else if (wr_mode) begin
         idle_ctl <= wdata[MODE_IDLE_BIT];
         wdog_en  <= wdata[MODE_WDOG_BIT];
         src_sel  <= cnt_src_e'(wdata[MODE_SRC_LSB +: 2]);
         ovf_ie   <= wdata[MODE_IE_BIT];
      end
   end

   // hardware sets take priority over a clearing write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 1'b0;
         cf  <= 1'b0;
         ccf <= '0;
      end else begin
         if (wr_ctrl) run <= wdata[CTRL_RUN_BIT];
         cf  <= (wr_ctrl ? wdata[CTRL_OVF_BIT] : cf) | hw_ovf;
         ccf <= (wr_ctrl ? wdata[N_MOD-1:0] : ccf) | mod_hit;
      end
   end

   generate
      if (N_MOD == CTRL_FLAGS_W) begin : g_flags_full
         assign flags_rd = ccf;
      end else begin : g_flags_pad
         assign flags_rd = {{(CTRL_FLAGS_W - N_MOD){1'b0}}, ccf};
      end
   endgenerate

   always_comb begin
      if (sel) rdata = {cf, run, 1'b0, flags_rd};
      else     rdata = {idle_ctl, wdog_en, 3'b000, src_sel, ovf_ie};
   end
endmodule

// File: rtl/pca_timebase.sv
module pca_timebase
   import pca_tb_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int N_MOD       = 5,
   parameter int SLOW_DIV    = 6,
   parameter int FAST_DIV    = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit EXT_PIN_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sfr_wr,
   input  logic             sfr_sel,
   input  logic [7:0]       sfr_wdata,
   output logic [7:0]       sfr_rdata,
   input  logic             half_speed,
   input  logic             cpu_idle,
   input  logic             tmr_ovf,
   input  logic             ext_pin,
   input  logic [N_MOD-1:0] mod_hit,
   output logic [CNT_W-1:0] count_o,
   output logic             ovf_irq,
   output logic             wdog_en
);
   localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

   // elaboration-time parameter checks
   generate
      if (CNT_W < 2) begin : g_bad_cnt_w
         $error("pca_timebase: CNT_W must be at least 2");
      end
      if (N_MOD < 1 || N_MOD > CTRL_FLAGS_W) begin : g_bad_n_mod
         $error("pca_timebase: N_MOD must lie in 1..5");
      end
      if (FAST_DIV < 1 || SLOW_DIV <= FAST_DIV) begin : g_bad_div
         $error("pca_timebase: need 1 <= FAST_DIV < SLOW_DIV");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pca_timebase: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic     idle_ctl, ovf_ie, run, cf, src_restart;
   cnt_src_e src_sel;
   logic [N_MOD-1:0] ccf;
   logic     div_tick, pin_rise, src_tick, cnt_en, hw_ovf;

   pca_sfr_regs #(.N_MOD(N_MOD)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (sfr_wr),
      .sel         (sfr_sel),
      .wdata       (sfr_wdata),
      .hw_ovf      (hw_ovf),
      .mod_hit     (mod_hit),
      .idle_ctl    (idle_ctl),
      .wdog_en     (wdog_en),
      .src_sel     (src_sel),
      .ovf_ie      (ovf_ie),
      .run         (run),
      .cf          (cf),
      .ccf         (ccf),
      .src_restart (src_restart),
      .rdata       (sfr_rdata)
   );

   pca_prescaler #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_presc (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (src_restart),
      .half_speed (half_speed),
      .fast_sel   (src_sel == SRC_DIV_FAST),
      .tick       (div_tick)
   );

   generate
      if (EXT_PIN_EN) begin : g_ext_pin
         pca_pin_edge #(.STAGES(SYNC_STAGES)) u_pin (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (ext_pin),
            .rise  (pin_rise)
         );
      end else begin : g_no_ext_pin
         logic unused_pin;
         assign unused_pin = ext_pin;
         assign pin_rise   = 1'b0;
      end
   endgenerate

   always_comb begin
      unique case (src_sel)
         SRC_DIV_SLOW,
         SRC_DIV_FAST: src_tick = div_tick;
         SRC_TMR_OVF:  src_tick = tmr_ovf;
         SRC_EXT_PIN:  src_tick = pin_rise;
         default:      src_tick = 1'b0;
      endcase
   end

   assign cnt_en  = run & ~(idle_ctl & cpu_idle) & src_tick;
   assign hw_ovf  = cnt_en & (count_o == CNT_TOP);
   assign ovf_irq = cf & ovf_ie;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count_o <= '0;
      else if (cnt_en) count_o <= count_o + 1'b1;
   end
endmodule

// File: rtl/pca_timebase_chk.sv
module pca_timebase_chk #(
   parameter int CNT_W = 16,
   parameter int N_MOD = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] count_o,
   input logic             cnt_en,
   input logic             run,
   input logic             idle_ctl,
   input logic             cpu_idle,
   input logic             cf,
   input logic             ovf_ie,
   input logic             ovf_irq,
   input logic [N_MOD-1:0] ccf,
   input logic [N_MOD-1:0] mod_hit,
   input logic             sfr_wr,
   input logic             sfr_sel
);
   // R1
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1));

   // R5
   run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(count_o));

   // R6
   idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_ctl && cpu_idle) |=> $stable(count_o));

   // R7
   ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && count_o == {CNT_W{1'b1}}) |=> cf);

   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cf && !(sfr_wr && sfr_sel)) |=> cf);

   // R8
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_irq) |-> ($rose(cf) || $rose(ovf_ie)));

   // R9
   hit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_hit != '0) |=> ((ccf & $past(mod_hit)) == $past(mod_hit)));
endmodule

bind pca_timebase pca_timebase_chk #(.CNT_W(CNT_W), .N_MOD(N_MOD)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .count_o  (count_o),
   .cnt_en   (cnt_en),
   .run      (run),
   .idle_ctl (idle_ctl),
   .cpu_idle (cpu_idle),
   .cf       (cf),
   .ovf_ie   (ovf_ie),
   .ovf_irq  (ovf_irq),
   .ccf      (ccf),
   .mod_hit  (mod_hit),
   .sfr_wr   (sfr_wr),
   .sfr_sel  (sfr_sel)
);

// File: tb/tb_pca_timebase.sv
`timescale 1ns/1ps
module tb_pca_timebase;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sfr_wr = 1'b0, sfr_sel = 1'b0;
   logic [7:0]  sfr_wdata = 8'h00;
   logic [7:0]  sfr_rdata;
   logic        half_speed = 1'b0, cpu_idle = 1'b0, tmr_ovf = 1'b0, ext_pin = 1'b0;
   logic [4:0]  mod_hit = 5'b0;
   logic [15:0] count_o;
   logic        ovf_irq, wdog_en;

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;
   string cur_req = "R10";

   always #2.5 clk = ~clk;

   pca_timebase dut (
      .clk(clk), .rst_n(rst_n), .sfr_wr(sfr_wr), .sfr_sel(sfr_sel),
      .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .half_speed(half_speed),
      .cpu_idle(cpu_idle), .tmr_ovf(tmr_ovf), .ext_pin(ext_pin),
      .mod_hit(mod_hit), .count_o(count_o), .ovf_irq(ovf_irq), .wdog_en(wdog_en)
   );

   // behavioural reference model
   int m_cnt, m_div, m_sel;
   bit m_s1, m_s2, m_s3, m_idlec, m_wdog, m_ie, m_run, m_cf;
   bit [4:0] m_ccf;

   always @(posedge clk) begin
      int lim;
      bit dtick, tick, en, hov;
      if (!rst_n) begin
         m_cnt = 0; m_div = 0; m_sel = 0;
         m_s1 = 0; m_s2 = 0; m_s3 = 0;
         m_idlec = 0; m_wdog = 0; m_ie = 0; m_run = 0; m_cf = 0; m_ccf = 0;
      end else begin
         lim = (m_sel == 1) ? 2 : 6;
         if (half_speed) lim = lim * 2;
         dtick = (m_div >= lim - 1);
         case (m_sel)
            0, 1:    tick = dtick;
            2:       tick = tmr_ovf;
            default: tick = m_s2 && !m_s3;
         endcase
         en  = m_run && !(m_idlec && cpu_idle) && tick;
         hov = en && (m_cnt == 65535);
         if (sfr_wr && !sfr_sel && int'(sfr_wdata[2:1]) != m_sel) m_div = 0;
         else if (dtick) m_div = 0;
         else m_div = m_div + 1;
         if (en) m_cnt = (m_cnt + 1) % 65536;
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
         if (sfr_wr && !sfr_sel) begin
            m_idlec = sfr_wdata[7]; m_wdog = sfr_wdata[6];
            m_sel = int'(sfr_wdata[2:1]); m_ie = sfr_wdata[0];
         end
         if (sfr_wr && sfr_sel) begin
            m_cf = sfr_wdata[7]; m_run = sfr_wdata[6]; m_ccf = sfr_wdata[4:0];
         end
         m_cf  = m_cf | hov;
         m_ccf = m_ccf | mod_hit;
      end
   end

   function automatic logic [7:0] exp_rdata();
      if (sfr_sel) return {m_cf, m_run, 1'b0, m_ccf};
      return {m_idlec, m_wdog, 3'b000, 2'(m_sel), m_ie};
   endfunction

   task automatic check(string req, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: got 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(cur_req, "count", int'(count_o), m_cnt);
         check(cur_req, "rdata", int'(sfr_rdata), int'(exp_rdata()));
         check("R8", "irq", int'(ovf_irq), int'(m_cf && m_ie));
         check("R10", "wdog_en", int'(wdog_en), int'(m_wdog));
      end
   end

   task automatic step(int n = 1);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic wr(bit sel, logic [7:0] d);
      sfr_wr = 1'b1; sfr_sel = sel; sfr_wdata = d;
      step();
      sfr_wr = 1'b0;
   endtask

   task automatic pin_pulses(int n);
      for (int i = 0; i < n; i++) begin
         ext_pin = 1'b1; step(3);
         ext_pin = 1'b0; step(3);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int saved;
      step(3);
      rst_n = 1'b1;
      step();
      // R10: reset values and reserved bits
      cur_req = "R10";
      sfr_sel = 1'b0; #1;
      check("R10", "mode after reset", int'(sfr_rdata), 'h00);
      sfr_sel = 1'b1; #1;
      check("R10", "ctrl after reset", int'(sfr_rdata), 'h00);
      wr(1'b0, 8'hFF);
      sfr_sel = 1'b0; #1;
      check("R10", "mode reserved", int'(sfr_rdata), 'hC7);
      check("R10", "wdog_en", int'(wdog_en), 1);
      wr(1'b1, 8'h20);
      check("R10", "ctrl reserved", int'(sfr_rdata), 'h00);

      // R1: slow internal tick
      cur_req = "R1";
      wr(1'b0, 8'h00);
      wr(1'b1, 8'h40);
      step(40);
      half_speed = 1'b1; step(50); half_speed = 1'b0;
      step(7);

      // R11: divider restart on source change
      cur_req = "R11";
      step(3);
      wr(1'b0, 8'h02);
      step(1);
      wr(1'b0, 8'h00);
      saved = int'(count_o);
      step(4);
      check("R11", "no early tick", int'(count_o), saved);
      step(20);

      // R2: fast internal tick
      cur_req = "R2";
      wr(1'b0, 8'h02);
      step(30);
      half_speed = 1'b1; step(30); half_speed = 1'b0;

      // R3: neighbouring timer overflow
      cur_req = "R3";
      wr(1'b0, 8'h04);
      saved = int'(count_o);
      for (int i = 0; i < 10; i++) begin
         tmr_ovf = 1'b1; step(); tmr_ovf = 1'b0; step(2);
      end
      check("R3", "ten pulses", int'(count_o), (saved + 10) % 65536);

      // R4: external pin edges
      cur_req = "R4";
      wr(1'b0, 8'h06);
      saved = int'(count_o);
      pin_pulses(8);
      ext_pin = 1'b1; step(12); ext_pin = 1'b0; step(4);
      check("R4", "nine edges", int'(count_o), (saved + 9) % 65536);

      // R5: run bit gating
      cur_req = "R5";
      wr(1'b1, 8'h00);
      saved = int'(count_o);
      pin_pulses(4);
      check("R5", "stopped", int'(count_o), saved);

      // R6: idle gating
      cur_req = "R6";
      wr(1'b1, 8'h40);
      wr(1'b0, 8'h86);
      cpu_idle = 1'b1;
      saved = int'(count_o);
      pin_pulses(4);
      check("R6", "idle frozen", int'(count_o), saved);
      wr(1'b0, 8'h06);
      pin_pulses(4);
      check("R6", "idle ignored", int'(count_o), (saved + 4) % 65536);
      cpu_idle = 1'b0;

      // R7 / R8: wrap, race with clearing write, software set/clear
      cur_req = "R7";
      wr(1'b0, 8'h05);
      tmr_ovf = 1'b1;
      while (m_cnt != 65535) step();
      sfr_wr = 1'b1; sfr_sel = 1'b1; sfr_wdata = 8'h40;
      step();
      sfr_wr = 1'b0;
      tmr_ovf = 1'b0;
      step();
      check("R7", "hw set beats clear", int'(sfr_rdata[7]), 1);
      check("R8", "irq after wrap", int'(ovf_irq), 1);
      wr(1'b1, 8'h40);
      check("R7", "sw clear", int'(sfr_rdata[7]), 0);
      check("R8", "irq cleared", int'(ovf_irq), 0);
      wr(1'b1, 8'hC0);
      check("R7", "sw set", int'(sfr_rdata[7]), 1);
      wr(1'b0, 8'h04);
      check("R8", "irq disabled", int'(ovf_irq), 0);

      // R9: channel flags
      cur_req = "R9";
      sfr_sel = 1'b1;
      wr(1'b1, 8'h80);
      mod_hit = 5'b00101; step(); mod_hit = 5'b0;
      #1;
      check("R9", "hits set", int'(sfr_rdata), 'h85);
      mod_hit = 5'b00010;
      wr(1'b1, 8'h80);
      mod_hit = 5'b0;
      #1;
      check("R9", "hit beats clear", int'(sfr_rdata), 'h82);
      mod_hit = 5'b10000; step(); mod_hit = 5'b0;
      step(3);
      check("R9", "flags sticky", int'(sfr_rdata), 'h92);
      wr(1'b1, 8'h00);
      check("R9", "sw clear", int'(sfr_rdata), 'h00);
      step(2);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule